// File: doc/BRIEF.md
# Machine Timer With Compare Interrupt

This block is a single-hart machine timer on a 32-bit word-addressed register bus. A 64-bit time count advances by a programmable step once every prescale+1 clock cycles while the timer is switched on. A 64-bit compare value is held alongside it. When the time has caught up with the compare value, a raw interrupt line to the core goes high.

A second, peripheral interrupt line is driven from a sticky status bit. The status bit is set by a compare hit while the enable bit is on, or by a test write. Software clears it by writing 1. Software sets the time, the compare value and the tick configuration through the bus.

The bus is a plain valid/write/address/wdata/rdata interface. A write takes effect on the clock edge where valid and write are both high. Read data is combinational from the current address. Address bits 1:0 are ignored.

Top module: `mtime_unit`

## Requirements
- R1: After reset the control word reads 0, the config word reads 0x00010000, both compare words read 0xFFFFFFFF, enable and status read 0, the time reads 0, and both interrupt outputs are low.
- R2: While control bit 0 (offset 0x04) is 0, the time count holds. While it is 1, the count grows by the step value once every prescale+1 cycles. The first step lands prescale+1 active edges after the prescaler was last restarted.
- R3: The config word (offset 0x100) keeps the prescale in bits 11:0 and the step in bits 23:16. It reads back with all other bits zero.
- R4: A write to time low (0x104) or time high (0x108) replaces that half on the write edge and restarts the prescaler from zero.
- R5: irq_mtimer is high exactly when control bit 0 is 1 and compare ({0x110,0x10C}) is less than or equal to the time. It is low whenever control bit 0 is 0.
- R6: In a cycle where irq_mtimer is high and enable bit 0 (0x114) is 1, status bit 0 (0x118) is set at the next edge and stays set after the compare condition goes away.
- R7: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R8: Writing 1 to bit 0 of the test word (0x11C) sets status bit 0 only when enable bit 0 is 1. Otherwise the write has no effect.
- R9: irq_periph is status bit 0 AND enable bit 0. Clearing the enable masks the output but keeps the status.
- R10: Reads of the alert word (0x00), the test word and unmapped offsets return 0. Writes to the alert word change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (12) | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_mtimer | output | 1 | Raw compare interrupt to the core |
| irq_periph | output | 1 | Enable-gated sticky interrupt |

## Verification
Errors show up at the ports at different speeds.

- A prescaler that is off by one shows within one prescale period. The time read back after a known number of active edges comes out one step too early or too late.
- A lost carry between the two time halves appears only when the low half wraps, so corner values near 0xFFFFFFFF are driven on purpose.
- The compare hit is visible on irq_mtimer in the same cycle it happens. A status latch that misses it shows one edge later on irq_periph, or on a status read after the compare is moved away.

// File: rtl/mtime_unit.sv
module mtime_unit #(
  parameter int AW     = 12,
  parameter int PRE_W  = 12,
  parameter int STEP_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq_mtimer,
  output logic          irq_periph
);
  localparam logic [AW-1:0] O_ALERT = AW'('h000);
  localparam logic [AW-1:0] O_CTRL  = AW'('h004);
  localparam logic [AW-1:0] O_CFG   = AW'('h100);
  localparam logic [AW-1:0] O_TLO   = AW'('h104);
  localparam logic [AW-1:0] O_THI   = AW'('h108);
  localparam logic [AW-1:0] O_CLO   = AW'('h10C);
  localparam logic [AW-1:0] O_CHI   = AW'('h110);
  localparam logic [AW-1:0] O_IE    = AW'('h114);
  localparam logic [AW-1:0] O_ST    = AW'('h118);
  localparam logic [AW-1:0] O_TST   = AW'('h11C);

  logic [AW-1:0]     word;
  logic              wr, tw, tick, hit, st_set, st_clr;
  logic              active, ie, st;
  logic [PRE_W-1:0]  pre_val, pre_cnt;
  logic [STEP_W-1:0] step;
  logic [63:0]       mtime, cmp;

  assign word   = {bus_addr[AW-1:2], 2'b00};
  assign wr     = bus_valid & bus_write;
  assign tw     = wr & ((word == O_TLO) | (word == O_THI));
  assign tick   = active & (pre_cnt >= pre_val);
  assign hit    = active & (cmp <= mtime);
  assign st_set = (hit & ie) | (wr & (word == O_TST) & bus_wdata[0] & ie);
  assign st_clr = wr & (word == O_ST) & bus_wdata[0];

  assign irq_mtimer = hit;
  assign irq_periph = st & ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      ie      <= 1'b0;
      pre_val <= '0;
      step    <= STEP_W'(1);
      cmp     <= '1;
    end else if (wr) begin
      if (word == O_CTRL) active  <= bus_wdata[0];
      if (word == O_IE)   ie      <= bus_wdata[0];
      if (word == O_CLO)  cmp[31:0]  <= bus_wdata;
      if (word == O_CHI)  cmp[63:32] <= bus_wdata;
      if (word == O_CFG) begin
        pre_val <= bus_wdata[PRE_W-1:0];
        step    <= bus_wdata[16 +: STEP_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mtime   <= '0;
      pre_cnt <= '0;
    end else if (tw) begin
      if (word == O_TLO) mtime[31:0]  <= bus_wdata;
      else               mtime[63:32] <= bus_wdata;
      pre_cnt <= '0;
    end else if (tick) begin
      mtime   <= mtime + 64'(step);
      pre_cnt <= '0;
    end else if (active) begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= 1'b0;
    else        st <= st_set | (st & ~st_clr);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (word)
        O_CTRL:  bus_rdata = {31'b0, active};
        O_CFG:   bus_rdata = (32'(step) << 16) | 32'(pre_val);
        O_TLO:   bus_rdata = mtime[31:0];
        O_THI:   bus_rdata = mtime[63:32];
        O_CLO:   bus_rdata = cmp[31:0];
        O_CHI:   bus_rdata = cmp[63:32];
        O_IE:    bus_rdata = {31'b0, ie};
        O_ST:    bus_rdata = {31'b0, st};
        O_ALERT: bus_rdata = '0;
        default: bus_rdata = '0;
      endcase
    end
  end

  p_hold_inactive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !tw) |=> mtime == $past(mtime));
  p_step_on_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tw && pre_cnt >= pre_val) |=> mtime == $past(mtime) + 64'($past(step)));
  p_time_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word == O_TLO) |=> (mtime[31:0] == $past(bus_wdata) && pre_cnt == '0));
  p_raw_needs_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mtimer |-> active);
  p_status_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mtimer && ie) |=> st);
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr && !(irq_mtimer && ie)) |=> !st);
  p_no_set_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie && !st) |=> !st);
endmodule

// File: tb/mtime_unit_bench.sv
module mtime_unit_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_mtimer, irq_periph;
  int total = 0, bad = 0;
  bit done = 0;

  mtime_unit u_mtime_unit (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_mtimer(irq_mtimer), .irq_periph(irq_periph));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [63:0] exp_time(logic [63:0] t0, int s, int p, int n);
    return t0 + 64'(s) * 64'(n / (p + 1));
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2;
    void'($urandom(32'd1234));
    idle(2);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk("R1 irq_mtimer", irq_mtimer, 0);
    chk("R1 irq_periph", irq_periph, 0);
    rd(12'h004, r); chk("R1 ctrl", r, 0);
    rd(12'h100, r); chk("R1 cfg", r, 32'h00010000);
    rd(12'h10C, r); chk("R1 cmp lo", r, 32'hFFFFFFFF);
    rd(12'h110, r); chk("R1 cmp hi", r, 32'hFFFFFFFF);
    rd(12'h114, r); chk("R1 ie", r, 0);
    rd(12'h118, r); chk("R1 status", r, 0);
    rd(12'h104, r); chk("R1 time lo", r, 0);

    // R10 write-only and unmapped reads, alert write ignored
    wr(12'h000, 32'hFFFFFFFF);
    rd(12'h000, r); chk("R10 alert read", r, 0);
    rd(12'h11C, r); chk("R10 test read", r, 0);
    rd(12'hFFC, r); chk("R10 unmapped read", r, 0);
    rd(12'h004, r); chk("R10 ctrl after alert", r, 0);
    rd(12'h118, r); chk("R10 status after alert", r, 0);
    rd(12'h104, r); chk("R10 time after alert", r, 0);

    // R2/R3 random prescale/step with counted edges
    for (int it = 0; it < 10; it++) begin
      int p, s, k;
      logic [63:0] t0, e;
      p = (it == 0) ? 0 : int'($urandom_range(0, 7));
      s = (it == 1) ? 255 : int'($urandom_range(0, 255));
      k = int'($urandom_range(0, 40));
      t0 = {$urandom, $urandom};
      if (it < 3) t0[31:0] = 32'hFFFFFFF0;
      wr(12'h100, 32'(s) << 16 | 32'(p) | 32'hFF00F000);
      rd(12'h100, r); chk("R3 cfg readback", r, (32'(s) << 16) | 32'(p));
      wr(12'h104, t0[31:0]);
      wr(12'h108, t0[63:32]);
      rd(12'h104, r); chk("R2 hold inactive lo", r, t0[31:0]);
      wr(12'h004, 1);
      idle(k);
      wr(12'h004, 0);
      e = exp_time(t0, s, p, k + 1);
      rd(12'h104, r); rd(12'h108, r2);
      chk("R2 time after run", {r2, r}, e);
      idle(3);
      rd(12'h104, r); chk("R2 held while off", r, e[31:0]);
    end

    // R4 time write while running restarts prescaler
    wr(12'h100, 32'h00010003);
    wr(12'h004, 1);
    idle(5);
    wr(12'h104, 32'h00000500);
    rd(12'h104, r); chk("R4 write visible", r, 32'h500);
    idle(2);
    rd(12'h104, r); chk("R4 prescaler restarted", r, 32'h500);
    rd(12'h104, r); chk("R4 first step", r, 32'h501);
    wr(12'h004, 0);

    // R5/R6 compare crossing
    wr(12'h100, 32'h00010000);
    wr(12'h104, 100);
    wr(12'h108, 0);
    wr(12'h110, 0);
    wr(12'h10C, 105);
    wr(12'h114, 1);
    wr(12'h004, 1);
    chk("R5 before hit", irq_mtimer, 0);
    idle(4);
    chk("R5 one before hit", irq_mtimer, 0);
    idle(1);
    chk("R5 at hit", irq_mtimer, 1);
    chk("R6 not yet latched", irq_periph, 0);
    idle(1);
    chk("R6 latched", irq_periph, 1);
    wr(12'h110, 1);
    chk("R5 compare moved away", irq_mtimer, 0);
    chk("R6 sticky", irq_periph, 1);
    // R7
    wr(12'h118, 0);
    rd(12'h118, r); chk("R7 write 0 keeps", r, 1);
    wr(12'h118, 1);
    rd(12'h118, r); chk("R7 write 1 clears", r, 0);
    chk("R7 irq low", irq_periph, 0);
    // R8/R9
    wr(12'h11C, 1);
    rd(12'h118, r); chk("R8 test sets", r, 1);
    chk("R8 irq up", irq_periph, 1);
    wr(12'h114, 0);
    chk("R9 masked", irq_periph, 0);
    rd(12'h118, r); chk("R9 status kept", r, 1);
    wr(12'h114, 1);
    chk("R9 unmasked", irq_periph, 1);
    wr(12'h114, 0);
    wr(12'h118, 1);
    wr(12'h11C, 1);
    rd(12'h118, r); chk("R8 test ignored without enable", r, 0);
    chk("R8 irq stays low", irq_periph, 0);

    // R5 inactive never raises
    wr(12'h004, 0);
    wr(12'h110, 0);
    wr(12'h10C, 0);
    chk("R5 inactive low", irq_mtimer, 0);
    wr(12'h114, 1);
    idle(2);
    rd(12'h118, r); chk("R6 no latch while inactive", r, 0);
    wr(12'h004, 1);
    chk("R5 active hit", irq_mtimer, 1);
    idle(1);
    chk("R6 latch after activate", irq_periph, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule